// File: doc/BRIEF.md
# Conditional Data-Processing ALU

This block is the arithmetic and logic core of a 32-bit integer datapath. It is combinational from its operands to its result and holds four status flags in a small register. A 4-bit opcode selects one of sixteen operations: bitwise logic, addition and subtraction in both operand orders, carry-chained forms of each, move and move-not, and four compare/test forms. The compare/test forms only update the flags and never produce a register write.

Execution depends on a condition. The surrounding decoder evaluates the condition code itself and presents the outcome on a pass input. A separate always input forces execution whatever the flags hold. When neither input is set, the block raises no write enable and leaves its flags untouched. Flag updates occur on the rising clock edge. They happen when set-flags is requested, and always for the compare/test opcodes.

Top module: `cdp_alu`

## Requirements
- R1: Opcode values select, in order 0 to 15: AND, EOR, SUB, RSB, ADD, ADC, SBC, RSC, TST, TEQ, CMP, CMN, ORR, MOV, BIC, MVN. AND, EOR and ORR give bitwise results, and BIC (14) gives opa AND NOT opb.
- R2: MOV (13) outputs opb and MVN (15) outputs NOT opb; the value of opa has no effect on either.
- R3: ADD gives opa+opb, ADC gives opa+opb+carry_in, SUB gives opa-opb, and SBC gives opa-opb+carry_in-1, all modulo 2^32.
- R4: RSB gives opb-opa and RSC gives opb-opa+carry_in-1.
- R5: TST (8), TEQ (9), CMP (10) and CMN (11) never assert result_we. They update the flags from opa AND opb, opa XOR opb, opa-opb and opa+opb respectively, even when set_flags is low.
- R6: When cond_pass and cond_always are both low, result_we is low and no flag changes at the next edge.
- R7: When cond_always is high, the operation executes even with cond_pass low.
- R8: For opcodes outside 8 to 11, the flags change only at a rising edge where set_flags is high and the operation executes.
- R9: An updated N equals bit 31 of the result, and an updated Z is 1 exactly when the result is zero.
- R10: An updated C is the carry out for addition forms and 1 when no borrow occurs for subtraction forms.
- R11: An updated V is 1 on signed overflow. For addition this means both addends have the same sign and the result sign differs. For subtraction it means the operand signs differ and the result sign differs from the minuend.
- R12: The logic forms (opcodes 0, 1, 8, 9, 12 to 15) update only N and Z; C and V keep their values.
- R13: Reset (rst_n low, asynchronous) clears all four flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags update on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op | input | 4 | Operation select |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| carry_in | input | 1 | Carry used by ADC, SBC, RSC |
| set_flags | input | 1 | Request a flag update |
| cond_pass | input | 1 | Condition evaluated true |
| cond_always | input | 1 | Execute regardless of condition |
| result | output | 32 | Operation result |
| result_we | output | 1 | Result write enable |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry / not-borrow flag |
| flag_v | output | 1 | Signed overflow flag |

## Verification
Two gating paths can act on the same cycle: the condition gate and the set-flags gate, and for the compare/test opcodes the forced flag update also acts on that cycle. The bench applies CMP with set_flags low while the condition passes, then applies CMP and ADD with the condition failing and set_flags high. It judges each case by the write enable seen before the edge and the flags read after it. A logic operation that follows an arithmetic one that set C and V shows whether the partial flag update kept those two bits.

// File: rtl/cdp_pkg.sv
package cdp_pkg;

   typedef enum logic [3:0] {
      OP_AND = 4'd0,  OP_EOR = 4'd1,  OP_SUB = 4'd2,  OP_RSB = 4'd3,
      OP_ADD = 4'd4,  OP_ADC = 4'd5,  OP_SBC = 4'd6,  OP_RSC = 4'd7,
      OP_TST = 4'd8,  OP_TEQ = 4'd9,  OP_CMP = 4'd10, OP_CMN = 4'd11,
      OP_ORR = 4'd12, OP_MOV = 4'd13, OP_BIC = 4'd14, OP_MVN = 4'd15
   } alu_op_e;

   function automatic logic is_compare(alu_op_e o);
      return (o == OP_TST) || (o == OP_TEQ) || (o == OP_CMP) || (o == OP_CMN);
   endfunction

   function automatic logic is_logic(alu_op_e o);
      case (o)
         OP_AND, OP_EOR, OP_TST, OP_TEQ,
         OP_ORR, OP_MOV, OP_BIC, OP_MVN: return 1'b1;
         default:                        return 1'b0;
      endcase
   endfunction

   function automatic logic is_swapped(alu_op_e o);
      return (o == OP_RSB) || (o == OP_RSC);
   endfunction

   function automatic logic is_subtract(alu_op_e o);
      case (o)
         OP_SUB, OP_RSB, OP_SBC, OP_RSC, OP_CMP: return 1'b1;
         default:                                return 1'b0;
      endcase
   endfunction

   function automatic logic uses_carry(alu_op_e o);
      return (o == OP_ADC) || (o == OP_SBC) || (o == OP_RSC);
   endfunction

endpackage

// File: rtl/cdp_logic_unit.sv
module cdp_logic_unit
   import cdp_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  alu_op_e            op,
   input  logic [WIDTH-1:0]   opa,
   input  logic [WIDTH-1:0]   opb,
   output logic [WIDTH-1:0]   out
);

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      always_comb begin
         case (op)
            OP_AND, OP_TST: out[i] = opa[i] & opb[i];
            OP_EOR, OP_TEQ: out[i] = opa[i] ^ opb[i];
            OP_ORR:         out[i] = opa[i] | opb[i];
            OP_MOV:         out[i] = opb[i];
            OP_BIC:         out[i] = opa[i] & ~opb[i];
            OP_MVN:         out[i] = ~opb[i];
            default:        out[i] = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/cdp_arith_unit.sv
module cdp_arith_unit #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0]   opa,
   input  logic [WIDTH-1:0]   opb,
   input  logic               swap,
   input  logic               subtract,
   input  logic               cin,
   output logic [WIDTH-1:0]   sum,
   output logic               cout,
   output logic               ovf
);

   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] lhs;
   logic [WIDTH-1:0] rhs;
   logic [WIDTH-1:0] rhs_eff;
   logic [WIDTH:0]   total;

   always_comb begin
      lhs     = swap ? opb : opa;
      rhs     = swap ? opa : opb;
      rhs_eff = subtract ? ~rhs : rhs;
      total   = {1'b0, lhs} + {1'b0, rhs_eff} + {{WIDTH{1'b0}}, cin};
      sum     = total[WIDTH-1:0];
      cout    = total[WIDTH];
      ovf     = (lhs[MSB] == rhs_eff[MSB]) && (sum[MSB] != lhs[MSB]);
   end

endmodule

// File: rtl/cdp_flag_reg.sv
module cdp_flag_reg (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_nz,
   input  logic upd_cv,
   input  logic n_in,
   input  logic z_in,
   input  logic c_in,
   input  logic v_in,
   output logic n_q,
   output logic z_q,
   output logic c_q,
   output logic v_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         n_q <= 1'b0;
         z_q <= 1'b0;
      end else if (upd_nz) begin
         n_q <= n_in;
         z_q <= z_in;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         c_q <= 1'b0;
         v_q <= 1'b0;
      end else if (upd_cv) begin
         c_q <= c_in;
         v_q <= v_in;
      end
   end

endmodule

// File: rtl/cdp_alu.sv
module cdp_alu
   import cdp_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [3:0]         op,
   input  logic [WIDTH-1:0]   opa,
   input  logic [WIDTH-1:0]   opb,
   input  logic               carry_in,
   input  logic               set_flags,
   input  logic               cond_pass,
   input  logic               cond_always,
   output logic [WIDTH-1:0]   result,
   output logic               result_we,
   output logic               flag_n,
   output logic               flag_z,
   output logic               flag_c,
   output logic               flag_v
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_chk
      $error("cdp_alu: WIDTH must be at least 2");
   end

   alu_op_e          opc;
   logic             execute;
   logic             cmp_op;
   logic             log_op;
   logic             arith_cin;
   logic [WIDTH-1:0] logic_out;
   logic [WIDTH-1:0] arith_out;
   logic             arith_cout;
   logic             arith_ovf;
   logic             upd_nz;
   logic             upd_cv;

   assign opc       = alu_op_e'(op);
   assign execute   = cond_pass | cond_always;
   assign cmp_op    = is_compare(opc);
   assign log_op    = is_logic(opc);
   assign arith_cin = uses_carry(opc) ? carry_in : is_subtract(opc);

   cdp_logic_unit #(.WIDTH(WIDTH)) u_logic (
      .op  (opc),
      .opa (opa),
      .opb (opb),
      .out (logic_out)
   );

   cdp_arith_unit #(.WIDTH(WIDTH)) u_arith (
      .opa      (opa),
      .opb      (opb),
      .swap     (is_swapped(opc)),
      .subtract (is_subtract(opc)),
      .cin      (arith_cin),
      .sum      (arith_out),
      .cout     (arith_cout),
      .ovf      (arith_ovf)
   );

   assign result    = log_op ? logic_out : arith_out;
   assign result_we = execute & ~cmp_op;
   assign upd_nz    = execute & (set_flags | cmp_op);
   assign upd_cv    = upd_nz & ~log_op;

   cdp_flag_reg u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_nz (upd_nz),
      .upd_cv (upd_cv),
      .n_in   (result[MSB]),
      .z_in   (~|result),
      .c_in   (arith_cout),
      .v_in   (arith_ovf),
      .n_q    (flag_n),
      .z_q    (flag_z),
      .c_q    (flag_c),
      .v_q    (flag_v)
   );

endmodule

// File: rtl/cdp_alu_chk.sv
module cdp_alu_chk #(
   parameter int WIDTH = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [3:0]       op,
   input logic [WIDTH-1:0] result,
   input logic             result_we,
   input logic             set_flags,
   input logic             cond_pass,
   input logic             cond_always,
   input logic             flag_n,
   input logic             flag_z,
   input logic             flag_c,
   input logic             flag_v
);

   logic exec_w;
   logic cmp_w;
   logic logic_w;

   assign exec_w  = cond_pass | cond_always;
   assign cmp_w   = (op[3:2] == 2'b10);
   assign logic_w = (op == 4'd0) || (op == 4'd1) || (op == 4'd8) ||
                    (op == 4'd9) || (op[3:2] == 2'b11);

   // R5
   cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_w |-> !result_we);

   // R6
   cond_fail_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_w |-> !result_we);

   // R6
   cond_fail_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !exec_w |=> $stable({flag_n, flag_z, flag_c, flag_v}));

   // R8
   no_set_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_flags && !cmp_w) |=> $stable({flag_n, flag_z, flag_c, flag_v}));

   // R9
   n_follows_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_w && (set_flags || cmp_w)) |=> (flag_n == $past(result[WIDTH-1])));

   // R9
   z_follows_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_w && (set_flags || cmp_w)) |=> (flag_z == ($past(result) == '0)));

   // R12
   logic_keeps_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      logic_w |=> $stable({flag_c, flag_v}));

endmodule

bind cdp_alu cdp_alu_chk #(.WIDTH(WIDTH)) u_cdp_alu_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op          (op),
   .result      (result),
   .result_we   (result_we),
   .set_flags   (set_flags),
   .cond_pass   (cond_pass),
   .cond_always (cond_always),
   .flag_n      (flag_n),
   .flag_z      (flag_z),
   .flag_c      (flag_c),
   .flag_v      (flag_v)
);

// File: tb/test_cdp_alu.sv
`timescale 1ns/100ps
module test_cdp_alu;

   typedef struct packed {
      logic [3:0]  op;
      logic [31:0] a;
      logic [31:0] b;
      logic        cin;
      logic [31:0] res;
      logic        we;
      logic [3:0]  nzcv;
   } vec_t;

   localparam int NVEC = 18;

   // Applied in sequence with set_flags=1, cond_pass=1; logic rows expect C,V of the row before.
   localparam vec_t VECS [NVEC] = '{
      '{4'd4,  32'hFFFFFFFF, 32'h00000001, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R3 R10 ADD carry out
      '{4'd0,  32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 32'hF000F000, 1'b1, 4'b1010}, // R1 R12 AND
      '{4'd1,  32'hF0F0F0F0, 32'hFF00FF00, 1'b0, 32'h0FF00FF0, 1'b1, 4'b0010}, // R1 EOR
      '{4'd2,  32'h00000005, 32'h00000007, 1'b0, 32'hFFFFFFFE, 1'b1, 4'b1000}, // R3 R10 SUB borrow
      '{4'd3,  32'h00000005, 32'h00000007, 1'b0, 32'h00000002, 1'b1, 4'b0010}, // R4 RSB
      '{4'd5,  32'h7FFFFFFF, 32'h00000000, 1'b1, 32'h80000000, 1'b1, 4'b1001}, // R3 R11 ADC overflow
      '{4'd6,  32'h0000000A, 32'h00000003, 1'b0, 32'h00000006, 1'b1, 4'b0010}, // R3 SBC
      '{4'd7,  32'h00000003, 32'h0000000A, 1'b1, 32'h00000007, 1'b1, 4'b0010}, // R4 RSC
      '{4'd8,  32'h000000F0, 32'h0000000F, 1'b0, 32'h00000000, 1'b0, 4'b0110}, // R5 TST
      '{4'd9,  32'h80000000, 32'h00000000, 1'b0, 32'h80000000, 1'b0, 4'b1010}, // R5 TEQ
      '{4'd10, 32'h80000000, 32'h00000001, 1'b0, 32'h7FFFFFFF, 1'b0, 4'b0011}, // R5 R11 CMP overflow
      '{4'd11, 32'h80000000, 32'h80000000, 1'b0, 32'h00000000, 1'b0, 4'b0111}, // R5 R10 CMN
      '{4'd12, 32'h00FF0000, 32'h0000FF00, 1'b0, 32'h00FFFF00, 1'b1, 4'b0011}, // R1 R12 ORR
      '{4'd13, 32'hDEADBEEF, 32'h12345678, 1'b0, 32'h12345678, 1'b1, 4'b0011}, // R2 MOV
      '{4'd14, 32'hFFFF0000, 32'hFF00FF00, 1'b0, 32'h00FF0000, 1'b1, 4'b0011}, // R1 BIC
      '{4'd15, 32'h12345678, 32'h00000000, 1'b0, 32'hFFFFFFFF, 1'b1, 4'b1011}, // R2 R9 MVN
      '{4'd2,  32'h00000007, 32'h00000007, 1'b0, 32'h00000000, 1'b1, 4'b0110}, // R9 R10 SUB zero
      '{4'd4,  32'h7FFFFFFF, 32'h00000001, 1'b0, 32'h80000000, 1'b1, 4'b1001}  // R11 ADD overflow
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  op = '0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        carry_in = 1'b0;
   logic        set_flags = 1'b0;
   logic        cond_pass = 1'b0;
   logic        cond_always = 1'b0;
   logic [31:0] result;
   logic        result_we;
   logic        flag_n, flag_z, flag_c, flag_v;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   cdp_alu #(.WIDTH(32)) i_cdp_alu (
      .clk(clk), .rst_n(rst_n), .op(op), .opa(opa), .opb(opb),
      .carry_in(carry_in), .set_flags(set_flags), .cond_pass(cond_pass),
      .cond_always(cond_always), .result(result), .result_we(result_we),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Drive after a falling edge, check combinational outputs, then flags after the rising edge.
   task automatic apply(input string tag, input logic [3:0] o, input logic [31:0] a,
                        input logic [31:0] b, input logic ci, input logic sf,
                        input logic cp, input logic ca, input logic [31:0] eres,
                        input logic ewe, input logic [3:0] eflags);
      @(negedge clk);
      op = o; opa = a; opb = b; carry_in = ci;
      set_flags = sf; cond_pass = cp; cond_always = ca;
      #1;
      check({tag, " result"}, result, eres);
      check({tag, " write"}, {31'd0, result_we}, {31'd0, ewe});
      @(posedge clk);
      #1;
      check({tag, " flags"}, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, eflags});
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      check("R13 reset flags", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NVEC; i++) begin
         apply($sformatf("R1-table row %0d", i), VECS[i].op, VECS[i].a, VECS[i].b,
               VECS[i].cin, 1'b1, 1'b1, 1'b0, VECS[i].res, VECS[i].we, VECS[i].nzcv);
      end

      // flags now 1001
      apply("R6 fail ADD", 4'd4, 32'd1, 32'd1, 1'b0, 1'b1, 1'b0, 1'b0, 32'd2, 1'b0, 4'b1001);
      apply("R6 fail CMP", 4'd10, 32'd3, 32'd3, 1'b0, 1'b1, 1'b0, 1'b0, 32'd0, 1'b0, 4'b1001);
      apply("R7 always SUB", 4'd2, 32'd3, 32'd3, 1'b0, 1'b1, 1'b0, 1'b1, 32'd0, 1'b1, 4'b0110);
      apply("R8 no set ADD", 4'd4, 32'd1, 32'd1, 1'b0, 1'b0, 1'b1, 1'b0, 32'd2, 1'b1, 4'b0110);
      apply("R5 CMP no set", 4'd10, 32'd1, 32'd2, 1'b0, 1'b0, 1'b1, 1'b0, 32'hFFFFFFFF, 1'b0, 4'b1000);
      apply("R2 MOV opa alt", 4'd13, 32'h0, 32'h12345678, 1'b1, 1'b0, 1'b1, 1'b0, 32'h12345678, 1'b1, 4'b1000);
      apply("R12 EOR keeps CV", 4'd4, 32'h80000000, 32'h80000000, 1'b0, 1'b1, 1'b1, 1'b0, 32'd0, 1'b1, 4'b0111);
      apply("R12 EOR after", 4'd1, 32'h0000FFFF, 32'h0000FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 32'd0, 1'b1, 4'b0111);

      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R13 async reset", {28'd0, flag_n, flag_z, flag_c, flag_v}, 32'd0);
      rst_n = 1'b1;

      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule